// File: doc/BRIEF.md
# Serial-Load DAC Input Register

This block is the digital front end of a 12-bit voltage-output converter. A host sends a code one bit at a time, most significant bit first. Each bit is captured on a rising edge of a serial clock, but only while an active-low select is asserted. The captured word waits in a shift register until an active-low load strobe copies it into the holding register, which sets the converter output. An active-low clear input forces the holding register to zero.

Load and clear never need the serial clock, and select has no effect on either of them. All five host pins are brought into a fast system clock domain through synchronizers. The serial clock edge is found by oversampling, so "asynchronous" here means independent of the serial clock. Alongside the code, the block outputs the ideal output level in microvolts, at 500 µV per code step, for comparison with measured values.

Top module: `dac_serial_front`

## Requirements
- R1: The shift register and the holding register are each 12 bits wide, and `dac_code` always shows the holding register.
- R2: With select low, exactly 12 serial clock pulses shift in a word, most significant bit first, so the first bit sent ends up as bit 11 of the code.
- R3: Only a rising serial clock edge shifts. A falling edge leaves the shift register unchanged.
- R4: While `ser_cs_n` is high, serial clock edges do not change the shift register.
- R5: While `load_n` is low and `clear_n` is high, the holding register takes the shift register contents, whatever the level of `ser_cs_n`.
- R6: While `clear_n` is low, the holding register is zero. This holds even when `load_n` is also low.
- R7: While `load_n` stays low, the holding register tracks further shifts. Once `load_n` returns high, it keeps its value.
- R8: A synchronous reset (`rst` high) clears both the shift register and the holding register.
- R9: `out_uv` equals the code times 500 µV, so code 0xFFF gives 2047500.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the host pins |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock; the rising edge shifts |
| ser_cs_n | input | 1 | Active-low select that gates shifting only |
| ser_din | input | 1 | Serial data, most significant bit first |
| load_n | input | 1 | Active-low transfer strobe, level sensitive |
| clear_n | input | 1 | Active-low clear of the holding register |
| dac_code | output | 12 | Holding register contents |
| out_uv | output | 21 | Ideal output level in microvolts |

## Verification
A corrupted shift register cannot be seen directly. It shows up only when a later load strobe copies it to `dac_code`, so every shift scenario ends with a load and a compare, a few system cycles after the strobe. A wrong holding register shows at `dac_code` and `out_uv` within the synchronizer latency plus one cycle. The bench therefore waits for that latency after each pin change and then checks. Clear priority and hold-after-load are checked by changing the shift register while the other strobe is held, then releasing it.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

    localparam int CODE_W  = 12;
    localparam int STEP_UV = 500;
    localparam int FULL_UV = ((1 << CODE_W) - 1) * STEP_UV;
    localparam int UV_W    = $clog2(FULL_UV + 1);

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [UV_W-1:0]   uv_t;

    // Host pins as one bundle, synchronized together
    typedef struct packed {
        logic sclk;
        logic cs_n;
        logic sdi;
        logic ld_n;
        logic clr_n;
    } pins_t;

    localparam pins_t PINS_IDLE = '{sclk: 1'b0, cs_n: 1'b1, sdi: 1'b0,
                                    ld_n: 1'b1, clr_n: 1'b1};

    typedef enum logic [1:0] {
        HOLD_KEEP  = 2'd0,
        HOLD_LOAD  = 2'd1,
        HOLD_CLEAR = 2'd2
    } hold_op_t;

    function automatic uv_t code_to_uv(input code_t c);
        return uv_t'(c) * uv_t'(STEP_UV);
    endfunction

endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dacfe_shift.sv
module dacfe_shift
    import dacfe_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sclk,
    input  logic  cs_n,
    input  logic  sdi,
    output code_t shreg
);
    logic  sclk_q;
    logic  rise;
    code_t sr;

    assign rise = sclk & ~sclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            sr     <= '0;
        end else begin
            sclk_q <= sclk;
            if (rise && !cs_n) sr <= {sr[CODE_W-2:0], sdi};
        end
    end

    assign shreg = sr;
endmodule

// File: rtl/dacfe_hold.sv
module dacfe_hold
    import dacfe_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ld_n,
    input  logic  clr_n,
    input  code_t din,
    output code_t dout
);
    hold_op_t op;
    code_t    hr;

    always_comb begin
        if (!clr_n)     op = HOLD_CLEAR;
        else if (!ld_n) op = HOLD_LOAD;
        else            op = HOLD_KEEP;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hr <= '0;
        end else begin
            case (op)
                HOLD_CLEAR: hr <= '0;
                HOLD_LOAD:  hr <= din;
                default:    hr <= hr;
            endcase
        end
    end

    assign dout = hr;
endmodule

// File: rtl/dac_serial_front.sv
module dac_serial_front
    import dacfe_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ser_clk,
    input  logic                ser_cs_n,
    input  logic                ser_din,
    input  logic                load_n,
    input  logic                clear_n,
    output logic [CODE_W-1:0]   dac_code,
    output logic [UV_W-1:0]     out_uv
);
    localparam int PW = $bits(pins_t);

    pins_t pins_raw;
    pins_t pins_s;
    code_t shreg;
    code_t hold_q;

    assign pins_raw = '{sclk: ser_clk, cs_n: ser_cs_n, sdi: ser_din,
                        ld_n: load_n, clr_n: clear_n};

    dacfe_sync #(
        .W       (PW),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PINS_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins_raw),
        .q   (pins_s)
    );

    dacfe_shift u_shift (
        .clk   (clk),
        .rst   (rst),
        .sclk  (pins_s.sclk),
        .cs_n  (pins_s.cs_n),
        .sdi   (pins_s.sdi),
        .shreg (shreg)
    );

    dacfe_hold u_hold (
        .clk   (clk),
        .rst   (rst),
        .ld_n  (pins_s.ld_n),
        .clr_n (pins_s.clr_n),
        .din   (shreg),
        .dout  (hold_q)
    );

    assign dac_code = hold_q;
    assign out_uv   = code_to_uv(hold_q);
endmodule

// File: rtl/dacfe_chk.sv
module dacfe_chk
    import dacfe_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input pins_t pins,
    input code_t shreg,
    input code_t dac,
    input uv_t   uv
);
    logic sclk_prev;

    always_ff @(posedge clk) begin
        if (rst) sclk_prev <= 1'b0;
        else     sclk_prev <= pins.sclk;
    end

    assert_shift_msb_first_R2: assert property (@(posedge clk) disable iff (rst)
        (pins.sclk && !sclk_prev && !pins.cs_n)
        |=> shreg == {$past(shreg[CODE_W-2:0]), $past(pins.sdi)});

    assert_no_shift_off_rise_R3: assert property (@(posedge clk) disable iff (rst)
        (!pins.sclk || sclk_prev) |=> $stable(shreg));

    assert_select_gates_R4: assert property (@(posedge clk) disable iff (rst)
        pins.cs_n |=> $stable(shreg));

    assert_load_copies_R5: assert property (@(posedge clk) disable iff (rst)
        (pins.clr_n && !pins.ld_n) |=> dac == $past(shreg));

    assert_clear_wins_R6: assert property (@(posedge clk) disable iff (rst)
        !pins.clr_n |=> dac == '0);

    assert_hold_stable_R7: assert property (@(posedge clk) disable iff (rst)
        (pins.clr_n && pins.ld_n) |=> $stable(dac));

    assert_reset_zero_R8: assert property (@(posedge clk)
        $past(rst) |-> (shreg == '0 && dac == '0));

    assert_full_scale_R9: assert property (@(posedge clk) disable iff (rst)
        (dac == '1) |-> (uv == uv_t'(FULL_UV)));
endmodule

bind dac_serial_front dacfe_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .pins  (pins_s),
    .shreg (shreg),
    .dac   (dac_code),
    .uv    (out_uv)
);

// File: tb/sim_dac_serial_front.sv
`timescale 1ns/1ps
module sim_dac_serial_front;
    localparam real CLK_NS = 5.0;
    localparam int  SETTLE = 6;
    localparam int  HALF   = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_clk = 1'b0;
    logic        ser_cs_n = 1'b1;
    logic        ser_din = 1'b0;
    logic        load_n = 1'b1;
    logic        clear_n = 1'b1;
    logic [11:0] dac_code;
    logic [20:0] out_uv;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_NS / 2.0) clk = ~clk;

    dac_serial_front u0 (
        .clk      (clk),
        .rst      (rst),
        .ser_clk  (ser_clk),
        .ser_cs_n (ser_cs_n),
        .ser_din  (ser_din),
        .load_n   (load_n),
        .clear_n  (clear_n),
        .dac_code (dac_code),
        .out_uv   (out_uv)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        ser_din = b;
        ser_clk = 1'b0;
        wait_cyc(HALF);
        ser_clk = 1'b1;
        wait_cyc(HALF);
        ser_clk = 1'b0;
    endtask

    task automatic send_word(input logic [11:0] w, input logic cs_n_level);
        ser_cs_n = cs_n_level;
        wait_cyc(HALF);
        for (int i = 11; i >= 0; i--) send_bit(w[i]);
        wait_cyc(HALF);
        ser_cs_n = 1'b1;
        wait_cyc(SETTLE);
    endtask

    task automatic pulse_load();
        load_n = 1'b0;
        wait_cyc(SETTLE);
        load_n = 1'b1;
        wait_cyc(SETTLE);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        wait_cyc(4);
        rst = 1'b0;
        wait_cyc(SETTLE);
        check("R8 code after reset", 32'(dac_code), 32'h0);
        check("R9 uv after reset", 32'(out_uv), 32'd0);
        pulse_load();
        check("R8 shift register empty after reset", 32'(dac_code), 32'h0);
    endtask

    task automatic t_shift_load(input logic [11:0] w);
        send_word(w, 1'b0);
        pulse_load();
        check("R2 R1 word assembled MSB first", 32'(dac_code), 32'(w));
        check("R9 uv scaling", 32'(out_uv), 32'(w) * 32'd500);
    endtask

    task automatic t_load_under_select();
        send_word(12'h3C6, 1'b0);
        ser_cs_n = 1'b0;
        pulse_load();
        ser_cs_n = 1'b1;
        check("R5 load with select low", 32'(dac_code), 32'h3C6);
    endtask

    task automatic t_falling_only();
        ser_clk = 1'b1;
        wait_cyc(SETTLE);
        ser_cs_n = 1'b0;
        ser_din = 1'b1;
        wait_cyc(SETTLE);
        ser_clk = 1'b0;
        wait_cyc(SETTLE);
        ser_cs_n = 1'b1;
        wait_cyc(SETTLE);
        pulse_load();
        check("R3 falling edge does not shift", 32'(dac_code), 32'h3C6);
    endtask

    task automatic t_cs_high();
        send_word(12'h333, 1'b1);
        pulse_load();
        check("R4 select high blocks shifting", 32'(dac_code), 32'h3C6);
    endtask

    task automatic t_clear_override();
        send_word(12'h7E1, 1'b0);
        clear_n = 1'b0;
        wait_cyc(SETTLE);
        check("R6 clear zeroes code", 32'(dac_code), 32'h0);
        load_n = 1'b0;
        wait_cyc(SETTLE);
        check("R6 clear beats load", 32'(dac_code), 32'h0);
        clear_n = 1'b1;
        wait_cyc(SETTLE);
        check("R5 load acts after clear release", 32'(dac_code), 32'h7E1);
        send_word(12'h001, 1'b0);
        check("R7 code tracks while load low", 32'(dac_code), 32'h001);
        load_n = 1'b1;
        wait_cyc(SETTLE);
        send_word(12'h5A5, 1'b0);
        check("R7 code held after load release", 32'(dac_code), 32'h001);
    endtask

    task automatic t_follow_one_bit();
        load_n = 1'b0;
        wait_cyc(SETTLE);
        check("R7 load low shows shift register", 32'(dac_code), 32'h5A5);
        ser_cs_n = 1'b0;
        wait_cyc(HALF);
        send_bit(1'b1);
        wait_cyc(SETTLE);
        ser_cs_n = 1'b1;
        check("R7 R2 single shift seen while load low", 32'(dac_code), 32'hB4B);
        load_n = 1'b1;
        wait_cyc(SETTLE);
    endtask

    initial begin
        t_reset();
        t_shift_load(12'hA5C);
        t_shift_load(12'hFFF);
        check("R9 full scale microvolts", 32'(out_uv), 32'd2047500);
        t_shift_load(12'h001);
        t_shift_load(12'h800);
        t_load_under_select();
        t_falling_only();
        t_cs_high();
        t_clear_override();
        t_follow_one_bit();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #(CLK_NS * 150000.0);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R1 actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule